// File: doc/BRIEF.md
# Recursive Multicast Chain Splitter

This block sits in each node of a mesh network and performs one step of a multicast that is built from plain unicasts. An arriving test packet carries, in its header, an ordered chain of destination addresses. The chain lists the node's own address among the others. The block finds the node in the chain and cuts the chain into a lower half and an upper half. It picks the single node that receives the packet in the next unicast step, and it produces two new chains. One chain travels with the forwarded packet. The other stays with this node for its own later steps.

Each node repeats the same step with the chain it keeps, and each receiver does the same with the chain it was handed. Because every step halves the work, a multicast to N destinations finishes in about log2(N)+1 unicast steps. The block accepts a new chain on every clock, so a fresh packet can start while earlier ones are still spreading. Routing the unicast, storing the packet and sorting the chain at the source are handled elsewhere.

Top module: `mc_chain_split`

## Requirements
- R1: An address is 6 bits, with X in bits [5:3] and Y in bits [2:0]. The chain packs entry k at bits [6k+5:6k], and entry 0 is the lowest in dimension order (X compared first, then Y). A chain holds up to 16 entries, and its length is given separately.
- R2: Every result appears in the clock cycle after `valid_i` is sampled high. `fwd_valid_o`, `err_o` and `done_o` are low in any cycle that does not follow an accepted input. The chain, length and next-hop outputs keep their last values until the next accepted input.
- R3: A chain of length L is cut into a lower part made of entries 0..floor(L/2)-1 and an upper part made of the remaining entries. All lengths are reported as entry counts.
- R4: If the node's own entry lies in the lower part, the next hop is the first entry of the upper part. The successor chain is the upper part, and the own chain is the lower part.
- R5: If the node's own entry lies in the upper part, the next hop is the last entry of the lower part. The successor chain is the lower part, and the own chain is the upper part, moved down so that it starts at slot 0.
- R6: For a chain of two entries, the packet is forwarded to the entry that is not the node itself. Both the successor and own lengths are 1, and `done_o` is high.
- R7: `done_o` is high exactly when the own chain after the step has length 1. For an input chain of length 1, `fwd_valid_o` stays low, `done_o` goes high, the own chain is the node's address, and the successor length and next hop are 0.
- R8: `err_o` is raised, and `fwd_valid_o` and `done_o` stay low, in any of these cases: the node's address does not occur in the first L entries, L is 0, or L exceeds 16. Both output lengths, both output chains and the next hop are then 0.
- R9: Output chain slots at or beyond the reported length are zero.
- R10: With `valid_i` held high, consecutive chains are processed on consecutive clocks, each with its own correct result.
- R11: While `rst_ni` is low, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Chain and address are presented this cycle |
| self_i | input | 6 | This node's address {X,Y} |
| chain_i | input | 96 | Received destination chain, entry k at [6k+5:6k] |
| len_i | input | 5 | Number of valid entries in chain_i |
| fwd_valid_o | output | 1 | A unicast to next_hop_o is requested |
| err_o | output | 1 | Own address missing or length out of range |
| done_o | output | 1 | Own chain reduced to this node alone |
| next_hop_o | output | 6 | Address of the successor |
| succ_chain_o | output | 96 | Chain handed to the successor |
| succ_len_o | output | 5 | Length of succ_chain_o |
| own_chain_o | output | 96 | Chain kept by this node |
| own_len_o | output | 5 | Length of own_chain_o |

## Verification
Every result is computed by combinational logic and captured in a single register stage, so each output is due one clock after the edge that samples `valid_i`. The bench drives each input on a falling edge and reads the outputs 1 ns after the next rising edge. It keeps `valid_i` high across the whole sweep, which covers every length from 1 to 16 and every position of the node in the chain, so each check falls in the one cycle that belongs to its own input. An idle cycle, read at the same offset, shows the strobes dropping while the data outputs hold their values. The error cases are driven the same way.

// File: rtl/mc_chain_pkg.sv
package mc_chain_pkg;
  localparam int unsigned MC_COORD_W = 3;
  localparam int unsigned MC_MAX_LEN = 16;

  function automatic int unsigned mc_len_w(int unsigned n);
    return $clog2(n + 1);
  endfunction
endpackage

// File: rtl/mc_self_locate.sv
module mc_self_locate #(
  parameter int unsigned ADDR_W  = 6,
  parameter int unsigned MAX_LEN = 16,
  parameter int unsigned LEN_W   = 5,
  parameter int unsigned IDX_W   = 4
) (
  input  logic [MAX_LEN*ADDR_W-1:0] chain_i,
  input  logic [LEN_W-1:0]          len_i,
  input  logic [ADDR_W-1:0]         self_i,
  output logic                      found_o,
  output logic [IDX_W-1:0]          idx_o
);
  // descending scan: lowest matching slot wins
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int k = MAX_LEN - 1; k >= 0; k--) begin
      if ((LEN_W'(k) < len_i) && (chain_i[k*ADDR_W +: ADDR_W] == self_i)) begin
        found_o = 1'b1;
        idx_o   = IDX_W'(k);
      end
    end
  end
endmodule

// File: rtl/mc_half_split.sv
module mc_half_split #(
  parameter int unsigned ADDR_W  = 6,
  parameter int unsigned MAX_LEN = 16,
  parameter int unsigned LEN_W   = 5,
  parameter int unsigned IDX_W   = 4
) (
  input  logic [MAX_LEN*ADDR_W-1:0] chain_i,
  input  logic [LEN_W-1:0]          len_i,
  input  logic [IDX_W-1:0]          idx_i,
  output logic [ADDR_W-1:0]         next_hop_o,
  output logic [MAX_LEN*ADDR_W-1:0] succ_chain_o,
  output logic [LEN_W-1:0]          succ_len_o,
  output logic [MAX_LEN*ADDR_W-1:0] own_chain_o,
  output logic [LEN_W-1:0]          own_len_o
);
  logic [ADDR_W-1:0] ent [MAX_LEN];
  logic [LEN_W-1:0]  half, rest;
  logic [IDX_W-1:0]  hi_base, lo_last;
  logic              lower;

  for (genvar g = 0; g < MAX_LEN; g++) begin : g_ent
    assign ent[g] = chain_i[g*ADDR_W +: ADDR_W];
  end

  always_comb begin
    half    = len_i >> 1;
    rest    = len_i - half;
    lower   = LEN_W'(idx_i) < half;
    hi_base = IDX_W'(half);
    lo_last = IDX_W'(half - LEN_W'(1));
    next_hop_o = lower ? ent[hi_base] : ent[lo_last];
    succ_len_o = lower ? rest : half;
    own_len_o  = lower ? half : rest;
    for (int j = 0; j < MAX_LEN; j++) begin
      logic [ADDR_W-1:0] lo_e, hi_e;
      lo_e = (LEN_W'(j) < half) ? ent[j] : '0;
      hi_e = (LEN_W'(j) < rest) ? ent[IDX_W'(j) + hi_base] : '0;
      succ_chain_o[j*ADDR_W +: ADDR_W] = lower ? hi_e : lo_e;
      own_chain_o[j*ADDR_W +: ADDR_W]  = lower ? lo_e : hi_e;
    end
  end
endmodule

// File: rtl/mc_chain_split.sv
module mc_chain_split
  import mc_chain_pkg::*;
#(
  parameter int unsigned COORD_W = MC_COORD_W,
  parameter int unsigned MAX_LEN = MC_MAX_LEN,
  localparam int unsigned ADDR_W = 2 * COORD_W,
  localparam int unsigned LEN_W  = mc_len_w(MAX_LEN),
  localparam int unsigned IDX_W  = $clog2(MAX_LEN),
  localparam int unsigned CH_W   = MAX_LEN * ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [ADDR_W-1:0] self_i,
  input  logic [CH_W-1:0]   chain_i,
  input  logic [LEN_W-1:0]  len_i,
  output logic              fwd_valid_o,
  output logic              err_o,
  output logic              done_o,
  output logic [ADDR_W-1:0] next_hop_o,
  output logic [CH_W-1:0]   succ_chain_o,
  output logic [LEN_W-1:0]  succ_len_o,
  output logic [CH_W-1:0]   own_chain_o,
  output logic [LEN_W-1:0]  own_len_o
);
  logic              found;
  logic [IDX_W-1:0]  idx;
  logic [ADDR_W-1:0] hop_c;
  logic [CH_W-1:0]   succ_c, own_c;
  logic [LEN_W-1:0]  succ_len_c, own_len_c;
  logic              ok, multi;

  mc_self_locate #(.ADDR_W(ADDR_W), .MAX_LEN(MAX_LEN), .LEN_W(LEN_W), .IDX_W(IDX_W)) u_loc (
    .chain_i (chain_i),
    .len_i   (len_i),
    .self_i  (self_i),
    .found_o (found),
    .idx_o   (idx)
  );

  mc_half_split #(.ADDR_W(ADDR_W), .MAX_LEN(MAX_LEN), .LEN_W(LEN_W), .IDX_W(IDX_W)) u_split (
    .chain_i      (chain_i),
    .len_i        (len_i),
    .idx_i        (idx),
    .next_hop_o   (hop_c),
    .succ_chain_o (succ_c),
    .succ_len_o   (succ_len_c),
    .own_chain_o  (own_c),
    .own_len_o    (own_len_c)
  );

  assign ok    = found && (len_i <= LEN_W'(MAX_LEN));
  assign multi = len_i > LEN_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fwd_valid_o  <= 1'b0;
      err_o        <= 1'b0;
      done_o       <= 1'b0;
      next_hop_o   <= '0;
      succ_chain_o <= '0;
      succ_len_o   <= '0;
      own_chain_o  <= '0;
      own_len_o    <= '0;
    end else begin
      fwd_valid_o <= valid_i && ok && multi;
      err_o       <= valid_i && !ok;
      done_o      <= valid_i && ok && (own_len_c == LEN_W'(1));
      if (valid_i) begin
        next_hop_o   <= (ok && multi) ? hop_c : '0;
        succ_chain_o <= ok ? succ_c : '0;
        succ_len_o   <= ok ? succ_len_c : '0;
        own_chain_o  <= ok ? own_c : '0;
        own_len_o    <= ok ? own_len_c : '0;
      end
    end
  end
endmodule

// File: rtl/mc_chain_split_chk.sv
module mc_chain_split_chk #(
  parameter int unsigned COORD_W = 3,
  parameter int unsigned MAX_LEN = 16,
  localparam int unsigned ADDR_W = 2 * COORD_W,
  localparam int unsigned LEN_W  = $clog2(MAX_LEN + 1),
  localparam int unsigned CH_W   = MAX_LEN * ADDR_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [LEN_W-1:0]  len_i,
  input logic              fwd_valid_o,
  input logic              err_o,
  input logic              done_o,
  input logic [ADDR_W-1:0] next_hop_o,
  input logic [CH_W-1:0]   succ_chain_o,
  input logic [LEN_W-1:0]  succ_len_o,
  input logic [LEN_W-1:0]  own_len_o
);
  logic [ADDR_W-1:0] succ_last;
  always_comb begin
    succ_last = '0;
    for (int k = 0; k < MAX_LEN; k++)
      if (LEN_W'(k + 1) == succ_len_o) succ_last = succ_chain_o[k*ADDR_W +: ADDR_W];
  end

  p_strobe_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fwd_valid_o || err_o || done_o) |-> $past(valid_i));
  p_len_sum_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fwd_valid_o |-> ((LEN_W+1)'(own_len_o) + (LEN_W+1)'(succ_len_o) == (LEN_W+1)'($past(len_i))));
  p_half_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fwd_valid_o |-> (own_len_o == ($past(len_i) >> 1) || succ_len_o == ($past(len_i) >> 1)));
  p_hop_edge_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fwd_valid_o |-> (next_hop_o == succ_chain_o[ADDR_W-1:0] || next_hop_o == succ_last));
  p_pair_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fwd_valid_o && $past(len_i) == LEN_W'(2)) |-> (done_o && succ_len_o == LEN_W'(1)));
  p_done_len_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> own_len_o == LEN_W'(1));
  p_err_excl_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (!fwd_valid_o && !done_o && own_len_o == '0 && succ_len_o == '0));
endmodule

bind mc_chain_split mc_chain_split_chk #(.COORD_W(COORD_W), .MAX_LEN(MAX_LEN)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .valid_i      (valid_i),
  .len_i        (len_i),
  .fwd_valid_o  (fwd_valid_o),
  .err_o        (err_o),
  .done_o       (done_o),
  .next_hop_o   (next_hop_o),
  .succ_chain_o (succ_chain_o),
  .succ_len_o   (succ_len_o),
  .own_len_o    (own_len_o)
);

// File: tb/mc_chain_split_test.sv
module mc_chain_split_test;
  localparam int MAX_LEN = 16;
  localparam int ADDR_W  = 6;
  localparam int LEN_W   = 5;
  localparam int CH_W    = MAX_LEN * ADDR_W;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              valid_i = 1'b0;
  logic [ADDR_W-1:0] self_i = '0;
  logic [CH_W-1:0]   chain_i = '0;
  logic [LEN_W-1:0]  len_i = '0;
  logic              fwd_valid_o, err_o, done_o;
  logic [ADDR_W-1:0] next_hop_o;
  logic [CH_W-1:0]   succ_chain_o, own_chain_o;
  logic [LEN_W-1:0]  succ_len_o, own_len_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #5 clk_i = ~clk_i;

  mc_chain_split uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .self_i(self_i),
    .chain_i(chain_i), .len_i(len_i), .fwd_valid_o(fwd_valid_o), .err_o(err_o),
    .done_o(done_o), .next_hop_o(next_hop_o), .succ_chain_o(succ_chain_o),
    .succ_len_o(succ_len_o), .own_chain_o(own_chain_o), .own_len_o(own_len_o)
  );

  // ascending {x,y} values, so dimension order holds; 62/63 never occur
  function automatic logic [ADDR_W-1:0] ent(int k, int salt);
    return ADDR_W'(k * 3 + salt);
  endfunction

  function automatic logic [CH_W-1:0] full_chain(int salt);
    logic [CH_W-1:0] c = '0;
    for (int k = 0; k < MAX_LEN; k++) c[k*ADDR_W +: ADDR_W] = ent(k, salt);
    return c;
  endfunction

  // entries first..first+n-1 packed from slot 0, rest zero
  function automatic logic [CH_W-1:0] sub_chain(int first, int n, int salt);
    logic [CH_W-1:0] c = '0;
    for (int j = 0; j < n; j++) c[j*ADDR_W +: ADDR_W] = ent(first + j, salt);
    return c;
  endfunction

  task automatic check(string req, string what, logic [CH_W-1:0] act, logic [CH_W-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic check_all(string req, logic v, logic e, logic d, logic [ADDR_W-1:0] hop,
                           logic [CH_W-1:0] sc, int sl, logic [CH_W-1:0] oc, int ol);
    check({req, " R10"}, "fwd_valid", CH_W'(fwd_valid_o), CH_W'(v));
    check(req, "err", CH_W'(err_o), CH_W'(e));
    check({req, " R7"}, "done", CH_W'(done_o), CH_W'(d));
    check({req, " R1"}, "next_hop", CH_W'(next_hop_o), CH_W'(hop));
    check({req, " R3 R9"}, "succ_chain", succ_chain_o, sc);
    check({req, " R3"}, "succ_len", CH_W'(succ_len_o), CH_W'(sl));
    check({req, " R3 R9"}, "own_chain", own_chain_o, oc);
    check({req, " R3"}, "own_len", CH_W'(own_len_o), CH_W'(ol));
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1;
    check_all("R11", 1'b0, 1'b0, 1'b0, '0, '0, 0, '0, 0);
    @(negedge clk_i) rst_ni = 1'b1;

    // full sweep, back-to-back
    for (int len = 1; len <= MAX_LEN; len++) begin
      for (int p = 0; p < len; p++) begin
        int h, salt;
        string req;
        salt = len;
        h = len / 2;
        @(negedge clk_i);
        valid_i = 1'b1;
        chain_i = full_chain(salt);
        len_i   = LEN_W'(len);
        self_i  = ent(p, salt);
        @(posedge clk_i);
        #1;
        if (len == 1) begin
          check_all("R7", 1'b0, 1'b0, 1'b1, '0, '0, 0, sub_chain(0, 1, salt), 1);
        end else if (p < h) begin
          req = (len == 2) ? "R6 R4" : "R4";
          check_all(req, 1'b1, 1'b0, (h == 1), ent(h, salt),
                    sub_chain(h, len - h, salt), len - h, sub_chain(0, h, salt), h);
        end else begin
          req = (len == 2) ? "R6 R5" : "R5";
          check_all(req, 1'b1, 1'b0, (len - h == 1), ent(h - 1, salt),
                    sub_chain(0, h, salt), h, sub_chain(h, len - h, salt), len - h);
        end
      end
    end

    // idle: strobes drop, data held (last case len 16, upper half, own len 8)
    @(negedge clk_i) valid_i = 1'b0;
    @(posedge clk_i);
    #1;
    check("R2", "fwd_valid idle", CH_W'(fwd_valid_o), '0);
    check("R2", "done idle", CH_W'(done_o), '0);
    check("R2", "own_len held", CH_W'(own_len_o), CH_W'(8));
    check("R2", "next_hop held", CH_W'(next_hop_o), CH_W'(ent(7, 16)));

    // error cases
    for (int c = 0; c < 4; c++) begin
      @(negedge clk_i);
      valid_i = 1'b1;
      chain_i = full_chain(1);
      case (c)
        0: begin len_i = 5'd5;  self_i = 6'd63; end
        1: begin len_i = 5'd0;  self_i = ent(0, 1); end
        2: begin len_i = 5'd17; self_i = ent(0, 1); end
        default: begin len_i = 5'd4; self_i = ent(4, 1); end
      endcase
      @(posedge clk_i);
      #1;
      check_all("R8", 1'b0, 1'b1, 1'b0, '0, '0, 0, '0, 0);
    end
    @(negedge clk_i) valid_i = 1'b0;
    @(posedge clk_i);
    #1;
    check("R8", "err clears", CH_W'(err_o), '0);

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule